// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

This block sits on a 14-bit address bus with 8-bit data. It turns each strobed transfer into a chip select for one of three regions, and it returns the read data of the selected target. The two top address bits pick the region. The working memory is 2 KB, split into eight 256-byte banks. The read-only store is 4 KB, split into four 1 KB banks. The peripheral area holds four interfaces, and each interface has four 8-bit registers.

The working memory banks and the peripheral registers are held inside the block. The read-only contents are computed from a fixed formula of the bank and the offset, so no storage is used for them. The block checks each region at its own granularity. The peripheral area is the only region in which every address bit is checked. An address that falls outside every mapped range raises an error flag and drives no select. A write to read-only space does the same. A read of such an address returns zero.

Top module: `bus_region_decoder`

## Requirements
- R1: Address bits 13:12 pick the region: 00 is working memory, 01 is read-only store, 10 is peripheral registers. Prefix 11 never decodes and always flags an error when a strobe is high.
- R2: In the working memory region bit 11 must be 0. Bits 10:8 pick bank b, which asserts `mem_sel[b]`, and bits 7:0 address the byte. Addresses 0800–0FFF flag an error.
- R3: In the read-only region bits 11:10 pick bank b, which asserts `rom_sel[b]` on a read, and bits 9:0 form the offset o. The byte read is o[7:0] XOR {b[1:0], o[9:8], 4'hA}.
- R4: In the peripheral region bits 11:4 must all be zero. Bits 3:2 pick interface i, which asserts `dev_sel[i]`, and bits 1:0 pick the register. Any other address with prefix 10 flags an error, and a write to it changes no register.
- R5: While the error flag is high, every select is low and the read data is 00.
- R6: A write to the read-only region raises the error flag, asserts no select and leaves the read-only data unchanged.
- R7: A write to working memory stores the data at the rising clock edge. A later read of the same address returns it. A write with bit 11 set does not alias onto a bank.
- R8: A peripheral register write takes effect at the rising clock edge. Reset clears every peripheral register to 00.
- R9: With neither strobe high, all selects, the error flag and the read data are zero. With both strobes high the transfer flags an error and writes nothing.
- R10: At most one select is ever high. A valid single-strobe transfer has exactly one select high, and its read data appears in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_addr | input | 14 | Transfer address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| mem_sel | output | 8 | One-hot select of the working memory banks |
| rom_sel | output | 4 | One-hot select of the read-only banks |
| dev_sel | output | 4 | One-hot select of the peripheral interfaces |
| bus_rdata | output | 8 | Read data of the selected target, 00 otherwise |
| bus_err | output | 1 | Decode error for the current transfer |

## Verification
The selects, the error flag and the read data are combinational in the address and the strobes. Each check on them is therefore taken in the same cycle as its stimulus, 2 ns after the falling edge on which the inputs changed. A write is visible only after the next rising edge, so a read-back check is driven no earlier than the following falling edge. Reset is released through two synchronising flops, and the bench waits three clock cycles after releasing it before it relies on the registers.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

  typedef enum logic [1:0] {
    RGN_MEM  = 2'b00,
    RGN_ROM  = 2'b01,
    RGN_DEV  = 2'b10,
    RGN_NONE = 2'b11
  } region_e;

  // Read-only contents: low offset byte mixed with bank and offset high bits
  function automatic logic [7:0] rom_byte(input logic [31:0] bank, input logic [31:0] ofs);
    return ofs[7:0] ^ {bank[1:0], ofs[9:8], 4'hA};
  endfunction

endpackage

// File: rtl/region_match.sv
module region_match
  import busdec_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int MEM_BANKS = 8,
  parameter int MEM_OFS_W = 8,
  parameter int ROM_BANKS = 4,
  parameter int ROM_OFS_W = 10,
  parameter int DEV_COUNT = 4,
  parameter int DEV_REG_W = 2
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [MEM_BANKS-1:0] mem_hit,
  output logic [ROM_BANKS-1:0] rom_hit,
  output logic [DEV_COUNT-1:0] dev_hit,
  output logic                 any_hit
);
  localparam int LOW_W     = ADDR_W - 2;
  localparam int MEM_SEL_W = $clog2(MEM_BANKS);
  localparam int ROM_SEL_W = $clog2(ROM_BANKS);
  localparam int DEV_SEL_W = $clog2(DEV_COUNT);
  localparam int MEM_TOP   = MEM_OFS_W + MEM_SEL_W;
  localparam int ROM_TOP   = ROM_OFS_W + ROM_SEL_W;
  localparam int DEV_TOP   = DEV_REG_W + DEV_SEL_W;

  region_e          rgn;
  logic [LOW_W-1:0] low;
  logic             mem_ok, rom_ok, dev_ok;
  logic [MEM_SEL_W-1:0] mem_idx;
  logic [ROM_SEL_W-1:0] rom_idx;
  logic [DEV_SEL_W-1:0] dev_idx;

  assign rgn     = region_e'(addr[ADDR_W-1 -: 2]);
  assign low     = addr[LOW_W-1:0];
  assign mem_idx = low[MEM_TOP-1:MEM_OFS_W];
  assign rom_idx = low[ROM_TOP-1:ROM_OFS_W];
  assign dev_idx = low[DEV_TOP-1:DEV_REG_W];

  // Each region checks the unused bits above its bank field
  assign mem_ok = (rgn == RGN_MEM) && ((low >> MEM_TOP) == '0);
  assign rom_ok = (rgn == RGN_ROM) && ((low >> ROM_TOP) == '0);
  assign dev_ok = (rgn == RGN_DEV) && ((low >> DEV_TOP) == '0);

  always_comb begin
    mem_hit = '0;
    rom_hit = '0;
    dev_hit = '0;
    if (mem_ok) mem_hit[mem_idx] = 1'b1;
    if (rom_ok) rom_hit[rom_idx] = 1'b1;
    if (dev_ok) dev_hit[dev_idx] = 1'b1;
  end

  assign any_hit = mem_ok | rom_ok | dev_ok;

  always_comb begin
    if (rgn == RGN_NONE) begin
      AST_PREFIX_NONE_MISS: assert (!any_hit); // R1
    end
  end

endmodule

// File: rtl/mem_banks.sv
module mem_banks #(
  parameter int BANKS  = 8,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANKS-1:0]  sel,
  input  logic              wen,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << OFS_W;

  logic [DATA_W-1:0] bank_q [BANKS];

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic [DATA_W-1:0] store [DEPTH];
    logic              bank_we;

    assign bank_we = wen & sel[g];

    always_ff @(posedge clk) begin
      if (bank_we) store[ofs] <= wdata;
    end

    assign bank_q[g] = store[ofs];

    AST_MEM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      bank_we |=> store[$past(ofs)] == $past(wdata)); // R7
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < BANKS; i++) begin
      if (sel[i]) rdata = bank_q[i];
    end
  end

endmodule

// File: rtl/dev_regs.sv
module dev_regs #(
  parameter int COUNT  = 4,
  parameter int REG_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COUNT-1:0]  sel,
  input  logic              wen,
  input  logic [REG_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int PER   = 1 << REG_W;
  localparam int TOTAL = COUNT * PER;
  localparam int FLAT_W = $clog2(TOTAL);

  logic [DATA_W-1:0] reg_q [TOTAL];
  logic [DATA_W-1:0] reg_d [TOTAL];
  logic [FLAT_W-1:0] flat;
  logic              hit;

  always_comb begin
    flat = '0;
    for (int i = 0; i < COUNT; i++) begin
      if (sel[i]) flat = FLAT_W'(i * PER) + FLAT_W'(reg_idx);
    end
  end

  assign hit = |sel;

  always_comb begin
    for (int i = 0; i < TOTAL; i++) reg_d[i] = reg_q[i];
    if (wen && hit) reg_d[flat] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) reg_q[i] <= '0;
    end else begin
      for (int i = 0; i < TOTAL; i++) reg_q[i] <= reg_d[i];
    end
  end

  assign rdata = hit ? reg_q[flat] : '0;

  AST_DEV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && hit) |=> reg_q[$past(flat)] == $past(wdata)); // R8

endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
  import busdec_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int MEM_BANKS = 8,
  parameter int MEM_OFS_W = 8,
  parameter int ROM_BANKS = 4,
  parameter int ROM_OFS_W = 10,
  parameter int DEV_COUNT = 4,
  parameter int DEV_REG_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  output logic [MEM_BANKS-1:0] mem_sel,
  output logic [ROM_BANKS-1:0] rom_sel,
  output logic [DEV_COUNT-1:0] dev_sel,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_err
);
  localparam int ROM_SEL_W = $clog2(ROM_BANKS);
  localparam int ROM_TOP   = ROM_OFS_W + ROM_SEL_W;
  localparam int SEL_W     = MEM_BANKS + ROM_BANKS + DEV_COUNT;

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic [MEM_BANKS-1:0] mem_hit;
  logic [ROM_BANKS-1:0] rom_hit;
  logic [DEV_COUNT-1:0] dev_hit;
  logic                 any_hit;

  region_match #(
    .ADDR_W(ADDR_W), .MEM_BANKS(MEM_BANKS), .MEM_OFS_W(MEM_OFS_W),
    .ROM_BANKS(ROM_BANKS), .ROM_OFS_W(ROM_OFS_W),
    .DEV_COUNT(DEV_COUNT), .DEV_REG_W(DEV_REG_W)
  ) u_match (
    .addr(bus_addr), .mem_hit(mem_hit), .rom_hit(rom_hit),
    .dev_hit(dev_hit), .any_hit(any_hit)
  );

  logic rd_only, wr_only, access, strobe;

  assign rd_only = bus_rd & ~bus_wr;
  assign wr_only = bus_wr & ~bus_rd;
  assign access  = rd_only | wr_only;
  assign strobe  = bus_rd | bus_wr;

  assign mem_sel = access  ? mem_hit : '0;
  assign rom_sel = rd_only ? rom_hit : '0;
  assign dev_sel = access  ? dev_hit : '0;

  assign bus_err = strobe & ((bus_rd & bus_wr) | ~any_hit | (wr_only & (|rom_hit)));

  logic [DATA_W-1:0] mem_q, dev_q, rom_q;
  logic [ROM_SEL_W-1:0] rom_bank;
  logic [ROM_OFS_W-1:0] rom_ofs;

  mem_banks #(
    .BANKS(MEM_BANKS), .OFS_W(MEM_OFS_W), .DATA_W(DATA_W)
  ) u_mem (
    .clk(clk), .rst_n(rst_n_int), .sel(mem_sel), .wen(wr_only),
    .ofs(bus_addr[MEM_OFS_W-1:0]), .wdata(bus_wdata), .rdata(mem_q)
  );

  dev_regs #(
    .COUNT(DEV_COUNT), .REG_W(DEV_REG_W), .DATA_W(DATA_W)
  ) u_dev (
    .clk(clk), .rst_n(rst_n_int), .sel(dev_sel), .wen(wr_only),
    .reg_idx(bus_addr[DEV_REG_W-1:0]), .wdata(bus_wdata), .rdata(dev_q)
  );

  assign rom_bank = bus_addr[ROM_TOP-1:ROM_OFS_W];
  assign rom_ofs  = bus_addr[ROM_OFS_W-1:0];
  assign rom_q    = DATA_W'(rom_byte(32'(rom_bank), 32'(rom_ofs)));

  always_comb begin
    bus_rdata = '0;
    if (rd_only) begin
      if (|mem_sel)      bus_rdata = mem_q;
      else if (|rom_sel) bus_rdata = rom_q;
      else if (|dev_sel) bus_rdata = dev_q;
    end
  end

  logic [SEL_W-1:0] all_sel;
  assign all_sel = {dev_sel, rom_sel, mem_sel};

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(all_sel)); // R10
  AST_VALID_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((bus_rd ^ bus_wr) && !bus_err) |-> $countones(all_sel) == 1); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(bus_rd || bus_wr) |-> (all_sel == '0 && !bus_err && bus_rdata == '0)); // R9
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_err |-> (all_sel == '0 && bus_rdata == '0)); // R5
  AST_ROM_WRITE_REJECT: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_wr && !bus_rd && bus_addr[ADDR_W-1 -: 2] == 2'b01) |-> (bus_err && rom_sel == '0)); // R6

endmodule

// File: tb/test_bus_region_decoder.sv
module test_bus_region_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  mem_sel;
  logic [3:0]  rom_sel;
  logic [3:0]  dev_sel;
  logic [7:0]  bus_rdata;
  logic        bus_err;

  int n_total = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  bus_region_decoder i_bus_region_decoder (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .mem_sel(mem_sel), .rom_sel(rom_sel),
    .dev_sel(dev_sel), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  // {addr, rd, wr, expected {dev,rom,mem} selects, expected error}
  localparam int NV = 14;
  localparam logic [32:0] VEC [NV] = '{
    {14'h0000, 1'b1, 1'b0, 16'h0001, 1'b0},  // R2 bank 0
    {14'h07FF, 1'b1, 1'b0, 16'h0080, 1'b0},  // R2 bank 7
    {14'h0345, 1'b0, 1'b1, 16'h0008, 1'b0},  // R2 write bank 3
    {14'h0800, 1'b1, 1'b0, 16'h0000, 1'b1},  // R2 bit 11 set
    {14'h1000, 1'b1, 1'b0, 16'h0100, 1'b0},  // R3 bank 0
    {14'h1FFF, 1'b1, 1'b0, 16'h0800, 1'b0},  // R3 bank 3
    {14'h1400, 1'b0, 1'b1, 16'h0000, 1'b1},  // R6 write to rom
    {14'h2000, 1'b1, 1'b0, 16'h1000, 1'b0},  // R4 dev 0
    {14'h200F, 1'b1, 1'b0, 16'h8000, 1'b0},  // R4 dev 3
    {14'h2010, 1'b1, 1'b0, 16'h0000, 1'b1},  // R4 bit 4 set
    {14'h2800, 1'b1, 1'b0, 16'h0000, 1'b1},  // R4 bit 11 set
    {14'h3000, 1'b1, 1'b0, 16'h0000, 1'b1},  // R1 prefix 11
    {14'h0100, 1'b0, 1'b0, 16'h0000, 1'b0},  // R9 idle
    {14'h0200, 1'b1, 1'b1, 16'h0000, 1'b1}   // R9 both strobes
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_exp(input logic [13:0] a);
    return a[7:0] ^ {a[11:10], a[9:8], 4'hA};
  endfunction

  task automatic rd_chk(input logic [13:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #2;
    chk({8'h00, bus_rdata}, {8'h00, exp}, tag);
    bus_rd = 1'b0;
  endtask

  task automatic wr_op(input logic [13:0] a, input logic [7:0] d, input logic both);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = both;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++; n_total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state: every peripheral register reads 00
    for (int k = 0; k < 16; k++) rd_chk(14'h2000 + 14'(k), 8'h00, "R8 reset value");

    // Decode table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      bus_addr = VEC[v][32:19]; bus_rd = VEC[v][18]; bus_wr = VEC[v][17]; bus_wdata = 8'h3C;
      #2;
      chk({dev_sel, rom_sel, mem_sel}, VEC[v][16:1], $sformatf("R1/R10 select vec %0d", v));
      chk({15'h0, bus_err}, {15'h0, VEC[v][0]}, $sformatf("R5 error vec %0d", v));
      if (VEC[v][0]) chk({8'h00, bus_rdata}, 16'h0000, $sformatf("R5 rdata vec %0d", v));
      bus_rd = 1'b0; bus_wr = 1'b0;
    end

    // R3 read-only contents
    rd_chk(14'h1000, rom_exp(14'h1000), "R3 rom 1000");
    rd_chk(14'h1ABC, 8'h16, "R3 rom 1ABC");
    rd_chk(14'h1FFF, rom_exp(14'h1FFF), "R3 rom 1FFF");

    // R7 working memory write and read back
    wr_op(14'h0123, 8'h5A, 1'b0);
    wr_op(14'h0723, 8'hC3, 1'b0);
    rd_chk(14'h0123, 8'h5A, "R7 bank 1 readback");
    rd_chk(14'h0723, 8'hC3, "R7 bank 7 readback");
    wr_op(14'h0923, 8'hEE, 1'b0);
    rd_chk(14'h0123, 8'h5A, "R7 no alias with bit 11");

    // R8 peripheral write
    wr_op(14'h2006, 8'h77, 1'b0);
    rd_chk(14'h2006, 8'h77, "R8 register write");
    rd_chk(14'h2005, 8'h00, "R8 neighbour untouched");
    // R4 out-of-range peripheral write changes nothing
    wr_op(14'h2016, 8'h99, 1'b0);
    rd_chk(14'h2006, 8'h77, "R4 bad dev write ignored");

    // R6 read-only write ignored
    wr_op(14'h1000, 8'h00, 1'b0);
    rd_chk(14'h1000, rom_exp(14'h1000), "R6 rom unchanged");

    // R9 both strobes write nothing
    wr_op(14'h0123, 8'hFF, 1'b1);
    rd_chk(14'h0123, 8'h5A, "R9 both strobes no write");

    // R9 idle outputs
    @(negedge clk);
    bus_addr = 14'h2006; bus_rd = 1'b0; bus_wr = 1'b0;
    #2;
    chk({bus_err, dev_sel, 3'b0, bus_rdata}, 16'h0000, "R9 idle outputs");

    // R10 same-cycle read data
    @(negedge clk);
    bus_addr = 14'h0723; bus_rd = 1'b1;
    #2;
    chk({8'h00, bus_rdata}, 16'h00C3, "R10 same-cycle data");
    bus_rd = 1'b0;

    // R8 reset clears registers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk(14'h2006, 8'h00, "R8 cleared by reset");

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule